// File: doc/BRIEF.md
# Traffic Load and Inter-Packet Gap Monitor

This block watches a byte-wide Ethernet reconciliation-layer stream, one octet per clock with a control flag, without touching it. Each octet is classified as part of a frame or as gap filler. Over a sliding window the block keeps three sums: the frame octets it saw, the number of gaps that ended, and the total idle octets in those gaps. These sums stand in for the average data rate and the average inter-packet gap, so no divider is needed.

The sums are compared against three programmable limits. A heavy-load flag rises when the frame-octet count in the window is above a traffic threshold. Two gap flags say whether the average gap is above the minimum gap and above the minimum average gap. A fourth flag says whether the most recent measured gap met the minimum gap. An idle-trimming engine further down the path would use these flags to decide when it may remove or restore idles. For a 10 Gb/s link the usual limits are 5 octets for the minimum gap and 12 octets for the minimum average gap.

The window is 2^(SLOT_LG2+NSLOT_LG2) cycles long (64 by default). It is built from 2^NSLOT_LG2 slots of 2^SLOT_LG2 cycles each, and it moves forward one slot at a time.

Top module: `traffic_ipg_monitor`

## Requirements
- R1: After reset every flag and every window sum is 0. `window_valid` rises at the clock edge that ends cycle WIN-1 after reset (cycle 0 is the first cycle with reset released) and then stays high. All four flags stay 0 while `window_valid` is 0.
- R2: An octet counts as a frame octet if it is a start (control flag 1, value 0xFB), or if it arrives while a frame is open. An open frame includes its own terminate (control flag 1, value 0xFD). `win_frame_octets` updates only at slot ends (every 2^SLOT_LG2 cycles). It then equals the frame octets in the last WIN cycles.
- R3: A gap opens at a terminate. Its length is the number of idle octets (control flag 1, value 0x07) that follow, up to the next start. Other control octets and data octets in the gap are not counted. The gap counts as one in `win_gap_count`, and its length is added to `win_gap_octets`, in the slot that holds the start octet. A start with no terminate before it since reset adds no gap.
- R4: `heavy_load` is high exactly when `window_valid` is high and `win_frame_octets` is strictly greater than `rate_thresh`.
- R5: `avg_above_min` is high exactly when `window_valid` is high, `win_gap_count` is not 0, and `win_gap_octets` is greater than `min_ipg` × `win_gap_count`.
- R6: `avg_above_min_avg` is high exactly when `window_valid` is high, `win_gap_count` is not 0, and `win_gap_octets` is greater than `min_avg_ipg` × `win_gap_count`.
- R7: At each start that closes a measured gap, the block records whether the gap length was at least `min_ipg`. The record is visible from the next cycle until the next measured gap. `last_gap_ok` shows this record while `window_valid` is high.
- R8: A gap length saturates at 2^GAP_W-1 (255 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Stream octet |
| rx_ctrl | input | 1 | 1 marks a control octet |
| rate_thresh | input | WIN_LG2+1 | Frame-octet count per window above which the load is heavy |
| min_ipg | input | GAP_W | Minimum gap in octets |
| min_avg_ipg | input | GAP_W | Minimum average gap in octets |
| heavy_load | output | 1 | Windowed frame octets above the threshold |
| last_gap_ok | output | 1 | Latest measured gap was at least `min_ipg` |
| avg_above_min | output | 1 | Average gap above `min_ipg` |
| avg_above_min_avg | output | 1 | Average gap above `min_avg_ipg` |
| window_valid | output | 1 | A full window has elapsed since reset |
| win_frame_octets | output | WIN_LG2+1 | Frame octets in the window |
| win_gap_octets | output | GAP_W+WIN_LG2+1 | Summed lengths of the gaps that ended in the window |
| win_gap_count | output | WIN_LG2+1 | Number of gaps that ended in the window |

## Verification
The assertions check on every cycle that:
- the flags stay low before the window has filled, and `window_valid` never drops once it is high;
- the window sums hold still between slot ends;
- the frame count never exceeds the window length;
- the gap flags are consistent with the gap count and with each other.

Only the bench's scenarios can show the exact sums and flag values. They require a reference view of which octets are frame and which are gap under different traffic shapes, which means:
- gaps of different lengths, including gaps equal to the limits;
- ordered sets and stray data inside gaps;
- a threshold set to exactly the window count;
- a saturated long gap;
- a start that arrives after reset with no terminate before it.

// File: rtl/tim_pkg.sv
// Shared constants and types for the traffic load and gap monitor.
package tim_pkg;
    // Control octet codes recognised on the stream.
    localparam logic [7:0] OCT_START = 8'hFB;
    localparam logic [7:0] OCT_TERM  = 8'hFD;
    localparam logic [7:0] OCT_IDLE  = 8'h07;

    // Where the stream is relative to packet boundaries.
    typedef enum logic [1:0] {
        LINK_UNSYNC = 2'd0,   // no terminate seen since reset
        LINK_FRAME  = 2'd1,   // inside a frame
        LINK_GAP    = 2'd2    // after a terminate, before the next start
    } link_e;
endpackage

// File: rtl/tim_classify.sv
// Octet classifier and gap tracker.
// Marks frame octets, reports the closing of each measured gap together
// with its length, and records whether that gap met the minimum gap limit.
// Assumes one octet per clock and a synchronous active-low reset.
module tim_classify #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       rx_data,
    input  logic             rx_ctrl,
    input  logic [GAP_W-1:0] min_ipg,
    output logic             frame_oct,
    output logic             gap_done,
    output logic [GAP_W-1:0] gap_len,
    output logic             gap_ok_raw
);
    import tim_pkg::*;

    link_e            link_q;
    logic [GAP_W-1:0] gap_q;
    logic             is_start, is_term, is_idle;

    // Decode the control codes of the current octet.
    always_comb begin
        is_start = rx_ctrl && (rx_data == OCT_START);
        is_term  = rx_ctrl && (rx_data == OCT_TERM);
        is_idle  = rx_ctrl && (rx_data == OCT_IDLE);
    end

    // Per-octet results for the window accumulator.
    always_comb begin
        frame_oct = is_start || (link_q == LINK_FRAME);
        gap_done  = is_start && (link_q == LINK_GAP);
        gap_len   = gap_q;
    end

    // Track the frame/gap state and count idles in the current gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= LINK_UNSYNC;
            gap_q  <= '0;
        end else if (is_start) begin
            link_q <= LINK_FRAME;
        end else if (is_term && (link_q == LINK_FRAME)) begin
            link_q <= LINK_GAP;
            gap_q  <= '0;
        end else if ((link_q == LINK_GAP) && is_idle && (gap_q != '1)) begin
            gap_q  <= gap_q + GAP_W'(1);
        end
    end

    // Record whether the most recently closed gap met the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_ok_raw <= 1'b0;
        end else if (gap_done) begin
            gap_ok_raw <= (gap_q >= min_ipg);
        end
    end
endmodule

// File: rtl/tim_window.sv
// Sliding-window accumulator.
// Splits the window into 2^NSLOT_LG2 slots of 2^SLOT_LG2 cycles. It keeps
// one stored total per slot and running window sums that are updated by
// add-new/subtract-oldest at each slot end, so no divider is needed.
// Assumes NSLOT_LG2 >= 1 and SLOT_LG2 >= 1.
module tim_window #(
    parameter int SLOT_LG2  = 4,
    parameter int NSLOT_LG2 = 2,
    parameter int GAP_W     = 8,
    localparam int WIN_LG2  = SLOT_LG2 + NSLOT_LG2,
    localparam int FR_W     = WIN_LG2 + 1,
    localparam int GSUM_W   = GAP_W + WIN_LG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_oct,
    input  logic              gap_done,
    input  logic [GAP_W-1:0]  gap_len,
    output logic [FR_W-1:0]   win_frame,
    output logic [GSUM_W-1:0] win_goct,
    output logic [FR_W-1:0]   win_gcnt,
    output logic              window_valid
);
    localparam int NSLOT = 1 << NSLOT_LG2;
    localparam int SF_W  = SLOT_LG2 + 1;
    localparam int SG_W  = GAP_W + SLOT_LG2 + 1;

    logic [SLOT_LG2-1:0]  phase_q;
    logic [NSLOT_LG2-1:0] ptr_q;
    logic [NSLOT_LG2:0]   seen_q;
    logic                 slot_end;

    logic [SF_W-1:0] acc_fr_q, acc_gc_q, acc_fr_nx, acc_gc_nx;
    logic [SG_W-1:0] acc_go_q, acc_go_nx;

    logic [SF_W-1:0] slot_fr [NSLOT];
    logic [SF_W-1:0] slot_gc [NSLOT];
    logic [SG_W-1:0] slot_go [NSLOT];
    logic [SF_W-1:0] old_fr, old_gc;
    logic [SG_W-1:0] old_go;

    // Slot end is the last cycle of each slot period.
    assign slot_end = (phase_q == '1);

    // Cycle position inside the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + SLOT_LG2'(1);
    end

    // Slot totals including the current cycle.
    always_comb begin
        acc_fr_nx = acc_fr_q + SF_W'(frame_oct);
        acc_gc_nx = acc_gc_q + SF_W'(gap_done);
        acc_go_nx = acc_go_q + (gap_done ? SG_W'(gap_len) : SG_W'(0));
    end

    // Open-slot accumulators, cleared as each slot closes.
    always_ff @(posedge clk) begin
        if (!rst_n || slot_end) begin
            acc_fr_q <= '0;
            acc_gc_q <= '0;
            acc_go_q <= '0;
        end else begin
            acc_fr_q <= acc_fr_nx;
            acc_gc_q <= acc_gc_nx;
            acc_go_q <= acc_go_nx;
        end
    end

    // One stored total per slot; the slot under the pointer is replaced.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [SF_W-1:0] fr_q, gc_q;
        logic [SG_W-1:0] go_q;

        // Capture the closing slot's totals into this ring position.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fr_q <= '0;
                gc_q <= '0;
                go_q <= '0;
            end else if (slot_end && (ptr_q == NSLOT_LG2'(s))) begin
                fr_q <= acc_fr_nx;
                gc_q <= acc_gc_nx;
                go_q <= acc_go_nx;
            end
        end

        assign slot_fr[s] = fr_q;
        assign slot_gc[s] = gc_q;
        assign slot_go[s] = go_q;
    end

    // Oldest slot totals, about to leave the window.
    always_comb begin
        old_fr = slot_fr[ptr_q];
        old_gc = slot_gc[ptr_q];
        old_go = slot_go[ptr_q];
    end

    // Ring pointer and count of slots closed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            seen_q <= '0;
        end else if (slot_end) begin
            ptr_q <= ptr_q + NSLOT_LG2'(1);
            if (seen_q != (NSLOT_LG2+1)'(NSLOT))
                seen_q <= seen_q + (NSLOT_LG2+1)'(1);
        end
    end

    // Window sums move by one slot at each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_frame <= '0;
            win_gcnt  <= '0;
            win_goct  <= '0;
        end else if (slot_end) begin
            win_frame <= win_frame - FR_W'(old_fr) + FR_W'(acc_fr_nx);
            win_gcnt  <= win_gcnt  - FR_W'(old_gc) + FR_W'(acc_gc_nx);
            win_goct  <= win_goct  - GSUM_W'(old_go) + GSUM_W'(acc_go_nx);
        end
    end

    assign window_valid = (seen_q == (NSLOT_LG2+1)'(NSLOT));
endmodule

// File: rtl/tim_compare.sv
// Threshold comparator.
// Turns the window sums into the load and gap flags. Average-gap tests
// multiply the limit by the gap count instead of dividing. All flags are
// held low until the window has filled once.
module tim_compare #(
    parameter int WIN_LG2   = 6,
    parameter int GAP_W     = 8,
    localparam int FR_W     = WIN_LG2 + 1,
    localparam int GSUM_W   = GAP_W + WIN_LG2 + 1
) (
    input  logic              window_valid,
    input  logic [FR_W-1:0]   win_frame,
    input  logic [GSUM_W-1:0] win_goct,
    input  logic [FR_W-1:0]   win_gcnt,
    input  logic [FR_W-1:0]   rate_thresh,
    input  logic [GAP_W-1:0]  min_ipg,
    input  logic [GAP_W-1:0]  min_avg_ipg,
    input  logic              gap_ok_raw,
    output logic              heavy_load,
    output logic              avg_above_min,
    output logic              avg_above_min_avg,
    output logic              last_gap_ok
);
    logic [GSUM_W-1:0] lim_min, lim_avg;
    logic              have_gaps;

    // Scale each limit by the number of gaps in the window.
    always_comb begin
        lim_min   = GSUM_W'(min_ipg)     * GSUM_W'(win_gcnt);
        lim_avg   = GSUM_W'(min_avg_ipg) * GSUM_W'(win_gcnt);
        have_gaps = (win_gcnt != '0);
    end

    // Gate the comparisons with window validity.
    always_comb begin
        heavy_load        = window_valid && (win_frame > rate_thresh);
        avg_above_min     = window_valid && have_gaps && (win_goct > lim_min);
        avg_above_min_avg = window_valid && have_gaps && (win_goct > lim_avg);
        last_gap_ok       = window_valid && gap_ok_raw;
    end
endmodule

// File: rtl/traffic_ipg_monitor.sv
// Traffic load and inter-packet gap monitor (top).
// Observes a byte-serial reconciliation stream and reports the windowed
// frame-octet count, gap count and gap-octet total, plus heavy-load and
// gap-limit flags. The stream itself is never modified.
// Assumes one octet per clock and a synchronous active-low reset.
module traffic_ipg_monitor #(
    parameter int SLOT_LG2  = 4,
    parameter int NSLOT_LG2 = 2,
    parameter int GAP_W     = 8,
    localparam int WIN_LG2  = SLOT_LG2 + NSLOT_LG2,
    localparam int FR_W     = WIN_LG2 + 1,
    localparam int GSUM_W   = GAP_W + WIN_LG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_data,
    input  logic              rx_ctrl,
    input  logic [FR_W-1:0]   rate_thresh,
    input  logic [GAP_W-1:0]  min_ipg,
    input  logic [GAP_W-1:0]  min_avg_ipg,
    output logic              heavy_load,
    output logic              last_gap_ok,
    output logic              avg_above_min,
    output logic              avg_above_min_avg,
    output logic              window_valid,
    output logic [FR_W-1:0]   win_frame_octets,
    output logic [GSUM_W-1:0] win_gap_octets,
    output logic [FR_W-1:0]   win_gap_count
);
    logic             frame_oct, gap_done, gap_ok_raw;
    logic [GAP_W-1:0] gap_len;

    tim_classify #(.GAP_W(GAP_W)) u_classify (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_data    (rx_data),
        .rx_ctrl    (rx_ctrl),
        .min_ipg    (min_ipg),
        .frame_oct  (frame_oct),
        .gap_done   (gap_done),
        .gap_len    (gap_len),
        .gap_ok_raw (gap_ok_raw)
    );

    tim_window #(
        .SLOT_LG2  (SLOT_LG2),
        .NSLOT_LG2 (NSLOT_LG2),
        .GAP_W     (GAP_W)
    ) u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_oct    (frame_oct),
        .gap_done     (gap_done),
        .gap_len      (gap_len),
        .win_frame    (win_frame_octets),
        .win_goct     (win_gap_octets),
        .win_gcnt     (win_gap_count),
        .window_valid (window_valid)
    );

    tim_compare #(
        .WIN_LG2 (WIN_LG2),
        .GAP_W   (GAP_W)
    ) u_compare (
        .window_valid      (window_valid),
        .win_frame         (win_frame_octets),
        .win_goct          (win_gap_octets),
        .win_gcnt          (win_gap_count),
        .rate_thresh       (rate_thresh),
        .min_ipg           (min_ipg),
        .min_avg_ipg       (min_avg_ipg),
        .gap_ok_raw        (gap_ok_raw),
        .heavy_load        (heavy_load),
        .avg_above_min     (avg_above_min),
        .avg_above_min_avg (avg_above_min_avg),
        .last_gap_ok       (last_gap_ok)
    );
endmodule

// File: rtl/tim_checker.sv
// Protocol checker for the traffic load and gap monitor, bound to the top.
// Keeps its own slot-phase counter so it does not rely on internal state.
module tim_checker #(
    parameter int SLOT_LG2  = 4,
    parameter int NSLOT_LG2 = 2,
    parameter int GAP_W     = 8,
    localparam int WIN_LG2  = SLOT_LG2 + NSLOT_LG2,
    localparam int FR_W     = WIN_LG2 + 1,
    localparam int GSUM_W   = GAP_W + WIN_LG2 + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [GAP_W-1:0]  min_ipg,
    input logic [GAP_W-1:0]  min_avg_ipg,
    input logic              heavy_load,
    input logic              last_gap_ok,
    input logic              avg_above_min,
    input logic              avg_above_min_avg,
    input logic              window_valid,
    input logic [FR_W-1:0]   win_frame_octets,
    input logic [GSUM_W-1:0] win_gap_octets,
    input logic [FR_W-1:0]   win_gap_count
);
    localparam logic [FR_W-1:0] WIN = FR_W'(1 << WIN_LG2);

    logic [SLOT_LG2-1:0] chk_phase;

    // Independent cycle-in-slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_phase <= '0;
        else        chk_phase <= chk_phase + SLOT_LG2'(1);
    end

    // R1: no flag before the window has filled.
    a_r1_flags_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !window_valid |-> !(heavy_load || last_gap_ok || avg_above_min || avg_above_min_avg));

    // R1: validity is sticky.
    a_r1_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        window_valid |=> window_valid);

    // R2: sums move only at slot ends.
    a_r2_sums_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_phase != '1) |=> ($stable(win_frame_octets) && $stable(win_gap_octets)
                               && $stable(win_gap_count)));

    // R2: the window can hold at most WIN frame octets.
    a_r2_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
        win_frame_octets <= WIN);

    // R4: heavy load needs frame octets in the window.
    a_r4_heavy_needs_frames: assert property (@(posedge clk) disable iff (!rst_n)
        heavy_load |-> (win_frame_octets != '0));

    // R5: the average-gap flag needs at least one gap.
    a_r5_avg_needs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        avg_above_min |-> (win_gap_count != '0) && (win_gap_octets != '0));

    // R6: above the larger limit implies above the smaller one.
    a_r6_limits_ordered: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_above_min_avg && (min_avg_ipg >= min_ipg)) |-> avg_above_min);

    // R3: gap count cannot exceed half the window plus one.
    a_r3_gap_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        win_gap_count <= (WIN >> 1) + FR_W'(1));
endmodule

bind traffic_ipg_monitor tim_checker #(
    .SLOT_LG2  (SLOT_LG2),
    .NSLOT_LG2 (NSLOT_LG2),
    .GAP_W     (GAP_W)
) u_tim_checker (
    .clk               (clk),
    .rst_n             (rst_n),
    .min_ipg           (min_ipg),
    .min_avg_ipg       (min_avg_ipg),
    .heavy_load        (heavy_load),
    .last_gap_ok       (last_gap_ok),
    .avg_above_min     (avg_above_min),
    .avg_above_min_avg (avg_above_min_avg),
    .window_valid      (window_valid),
    .win_frame_octets  (win_frame_octets),
    .win_gap_octets    (win_gap_octets),
    .win_gap_count     (win_gap_count)
);

// File: tb/traffic_ipg_monitor_test.sv
// Scoreboard bench: the driver runs a reference model from the requirements
// and queues the expected outputs for every cycle; the monitor compares.
module traffic_ipg_monitor_test;
    localparam int SLOT  = 16;
    localparam int WIN   = 64;
    localparam int HIST  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = 8'h07;
    logic        rx_ctrl = 1'b1;
    logic [6:0]  rate_thresh = 7'd40;
    logic [7:0]  min_ipg = 8'd5;
    logic [7:0]  min_avg_ipg = 8'd12;
    logic        heavy_load, last_gap_ok, avg_above_min, avg_above_min_avg, window_valid;
    logic [6:0]  win_frame_octets, win_gap_count;
    logic [14:0] win_gap_octets;

    traffic_ipg_monitor #(.SLOT_LG2(4), .NSLOT_LG2(2), .GAP_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
        .rate_thresh(rate_thresh), .min_ipg(min_ipg), .min_avg_ipg(min_avg_ipg),
        .heavy_load(heavy_load), .last_gap_ok(last_gap_ok),
        .avg_above_min(avg_above_min), .avg_above_min_avg(avg_above_min_avg),
        .window_valid(window_valid), .win_frame_octets(win_frame_octets),
        .win_gap_octets(win_gap_octets), .win_gap_count(win_gap_count));

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        bit valid, heavy, gok, amin, aavg;
        int fr, go, gc;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state.
    int h_fr[HIST], h_gc[HIST], h_go[HIST];
    int n, m_state, m_gap, e_fr, e_gc, e_go;
    bit m_gok;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, n, act, exp);
        end
    endtask

    task automatic model_reset();
        n = 0; m_state = 0; m_gap = 0; m_gok = 0;
        e_fr = 0; e_gc = 0; e_go = 0;
    endtask

    // Reference behaviour for one sampled octet, then expected outputs.
    task automatic model_step(logic [7:0] d, logic c);
        bit s, t, i, fr, gd;
        int idx;
        exp_t e;
        s = c && (d == 8'hFB);
        t = c && (d == 8'hFD);
        i = c && (d == 8'h07);
        fr = s || (m_state == 1);
        gd = s && (m_state == 2);
        idx = n % HIST;
        h_fr[idx] = fr;
        h_gc[idx] = gd;
        h_go[idx] = gd ? m_gap : 0;
        if (gd) m_gok = (m_gap >= int'(min_ipg));
        if (s) m_state = 1;
        else if (t && m_state == 1) begin m_state = 2; m_gap = 0; end
        else if (m_state == 2 && i && m_gap < 255) m_gap++;
        n++;
        if (n % SLOT == 0) begin
            e_fr = 0; e_gc = 0; e_go = 0;
            for (int k = n - WIN; k < n; k++) begin
                if (k >= 0) begin
                    e_fr += h_fr[k % HIST];
                    e_gc += h_gc[k % HIST];
                    e_go += h_go[k % HIST];
                end
            end
        end
        e.valid = (n >= WIN);
        e.fr = e_fr; e.gc = e_gc; e.go = e_go;
        e.heavy = e.valid && (e_fr > int'(rate_thresh));
        e.amin  = e.valid && (e_gc != 0) && (e_go > int'(min_ipg) * e_gc);
        e.aavg  = e.valid && (e_gc != 0) && (e_go > int'(min_avg_ipg) * e_gc);
        e.gok   = e.valid && m_gok;
        q.push_back(e);
    endtask

    // Driver: called at a falling edge; drives one octet for one cycle.
    task automatic put(logic [7:0] d, logic c);
        rx_data = d;
        rx_ctrl = c;
        @(posedge clk);
        #1;
        model_step(d, c);
        @(negedge clk);
    endtask

    task automatic send_pkt(int len, int gap);
        put(8'hFB, 1'b1);
        for (int k = 0; k < len - 2; k++) put(8'(k + 8'h20), 1'b0);
        put(8'hFD, 1'b1);
        for (int k = 0; k < gap; k++) put(8'h07, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx_data = 8'h07;
        rx_ctrl = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        // R1: everything cleared right after reset.
        chk("R1 reset flags", int'({heavy_load, last_gap_ok, avg_above_min,
                                    avg_above_min_avg, window_valid}), 0);
        chk("R1 reset sums", int'(win_frame_octets) + int'(win_gap_octets)
                             + int'(win_gap_count), 0);
    endtask

    // Monitor: compares every queued expectation after the clock edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                e = q.pop_front();
                chk("R1 window_valid", int'(window_valid), int'(e.valid));
                chk("R2 win_frame_octets", int'(win_frame_octets), e.fr);
                chk("R3 win_gap_count", int'(win_gap_count), e.gc);
                chk("R3 win_gap_octets", int'(win_gap_octets), e.go);
                chk("R4 heavy_load", int'(heavy_load), int'(e.heavy));
                chk("R5 avg_above_min", int'(avg_above_min), int'(e.amin));
                chk("R6 avg_above_min_avg", int'(avg_above_min_avg), int'(e.aavg));
                chk("R7 last_gap_ok", int'(last_gap_ok), int'(e.gok));
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        do_reset();
        // Dense traffic, gap 5: heavy, gaps meet the minimum, average not above it.
        for (int p = 0; p < 12; p++) send_pkt(20, 5);
        // Gap equal to the minimum average: above min, not above min average (R6).
        for (int p = 0; p < 10; p++) send_pkt(20, 12);
        // Wider gaps: lighter load, both averages above the limits.
        for (int p = 0; p < 10; p++) send_pkt(20, 14);
        // Short gaps fail the minimum (R7).
        for (int p = 0; p < 6; p++) send_pkt(20, 3);
        // Ordered sets and stray data inside gaps are not idles (R3).
        for (int p = 0; p < 6; p++) begin
            send_pkt(20, 0);
            put(8'h9C, 1'b1); put(8'h55, 1'b0); put(8'h9C, 1'b1);
            for (int k = 0; k < 6; k++) put(8'h07, 1'b1);
        end
        // Long frame: threshold equal to the full window, then one below (R4).
        put(8'hFB, 1'b1);
        for (int k = 0; k < 100; k++) put(8'hAA, 1'b0);
        rate_thresh = 7'd64;
        for (int k = 0; k < 60; k++) put(8'hAA, 1'b0);
        rate_thresh = 7'd63;
        for (int k = 0; k < 60; k++) put(8'hAA, 1'b0);
        put(8'hFD, 1'b1);
        rate_thresh = 7'd40;
        // Long gap saturates at 255 octets (R8).
        for (int k = 0; k < 300; k++) put(8'h07, 1'b1);
        send_pkt(20, 4);
        chk("R8 saturated gap octets", int'(win_gap_octets), 255);
        chk("R8 single gap counted", int'(win_gap_count), 1);
        for (int p = 0; p < 4; p++) send_pkt(20, 6);
        // Reset with a start arriving before any terminate: no gap (R3).
        min_ipg = 8'd8;
        do_reset();
        send_pkt(30, 9);
        for (int p = 0; p < 8; p++) send_pkt(16, 8);
        for (int p = 0; p < 4; p++) send_pkt(16, 7);
        for (int k = 0; k < 40; k++) put(8'h07, 1'b1);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule